// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level, forward-mapped page table kept in ordinary memory. A request carries the virtual address together with the current table base and table length. The walker checks the outer index against the length. It then reads the outer entry, which points at an inner table, and reads the inner entry, which holds the frame number. It returns the frame joined with the page offset, or a fault code that says at which step the walk stopped.

Memory is reached through a simple read port. The walker raises a one-cycle read request with an address and then waits, for any number of cycles, for a read-valid strobe carrying the entry. Only one read is outstanding at a time. The walker accepts a new request only when it is idle, and it holds `busy` high until its one-cycle result has been presented.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `rsp_valid` and `mem_req` are all low.
- R2: The virtual address splits as outer index = bits 31:20, inner index = bits 19:10, page offset = bits 9:0. The first read goes to `tbl_base + outer_index*4`.
- R3: An entry is 32 bits, with bit 0 as its valid bit and bits 31:10 as a frame or table number. The second read goes to `{outer_entry[31:10], 10'b0} + inner_index*4`.
- R4: A successful walk returns `rsp_paddr = {inner_entry[31:10], vaddr[9:0]}` with `rsp_fault` = 0.
- R5: If the outer index is greater than or equal to `tbl_len`, the walk ends with `rsp_fault` = 1 and issues no memory read. An index of `tbl_len-1` is legal.
- R6: An outer entry with bit 0 clear ends the walk with `rsp_fault` = 2 after exactly one read.
- R7: An inner entry with bit 0 clear ends the walk with `rsp_fault` = 3 after exactly two reads.
- R8: A successful walk issues exactly two reads. Each `mem_req` lasts one cycle, and no new read is issued before the previous one has returned.
- R9: A request presented while `busy` is high is ignored. It neither changes the walk in progress nor starts another walk.
- R10: `busy` rises in the cycle after a request is accepted and stays high through the single cycle in which `rsp_valid` is high. It is low in the cycle after that.
- R11: The walker tolerates any read latency, including a response in the cycle right after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request, taken only when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | Physical byte address of the outer table |
| tbl_len | input | 13 | Number of legal outer entries (0 to 4096) |
| busy | output | 1 | Walk in progress or result being shown |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 2 | 0 ok, 1 length bound, 2 outer invalid, 3 inner invalid |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Page-table entry read back |

## Verification
The bench targets the length boundary from both sides: index `len-1`, index equal to `len`, a zero length, and the full 4096 length with the top index. An off-by-one comparator would fault a legal page or walk past the table. Faults at each level are checked with read counts, so a walker that reads memory before the bound check, or reads the inner table after a bad outer entry, shows an extra read. Requests raised in the middle of a walk and zero-latency responses are also exercised. A design that re-latched the address mid-walk, or that missed a response arriving in the first wait cycle, would return the wrong frame or hang.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_OUT = 3'd1,
    ST_WT_OUT = 3'd2,
    ST_RD_IN  = 3'd3,
    ST_WT_IN  = 3'd4,
    ST_DONE   = 3'd5
  } walk_st_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_BOUND = 2'd1,
    FLT_OUTER = 2'd2,
    FLT_INNER = 2'd3
  } walk_flt_e;

endpackage

// File: rtl/ptw_bound_chk.sv
module ptw_bound_chk #(
  parameter int OUT_W = 12
) (
  input  logic [OUT_W-1:0] idx,
  input  logic [OUT_W:0]   len,
  output logic             in_range
);
  assign in_range = ({1'b0, idx} < len);
endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int OUT_W = 12,
  parameter int ENT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic               load_inner,
  input  logic               load_frame,
  input  logic               sel_inner,
  input  logic [VA_W-1:0]    vaddr_in,
  input  logic [ENT_W-1:0]   base_in,
  input  logic [OUT_W:0]     len_in,
  input  logic [ENT_W-1:0]   rdata,
  output logic [OUT_W-1:0]   outer_idx,
  output logic [OUT_W:0]     len_q,
  output logic [ENT_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]   paddr
);
  localparam int IN_W  = VA_W - OFF_W - OUT_W;
  localparam int PA_W  = ENT_W;
  localparam int FRM_W = ENT_W - OFF_W;

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] tbase,
                                                 input logic [OUT_W-1:0] idx);
    return tbase + PA_W'({idx, 2'b00});
  endfunction

  function automatic logic [PA_W-1:0] table_of(input logic [ENT_W-1:0] ent);
    return {ent[ENT_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  logic [VA_W-1:0]  vaddr_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  inner_base_q;
  logic [FRM_W-1:0] frame_q;
  logic [IN_W-1:0]  inner_idx;
  logic             unused_rsvd;

  assign unused_rsvd = ^rdata[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q      <= '0;
      base_q       <= '0;
      len_q        <= '0;
      inner_base_q <= '0;
      frame_q      <= '0;
    end else begin
      if (capture) begin
        vaddr_q <= vaddr_in;
        base_q  <= base_in;
        len_q   <= len_in;
      end
      if (load_inner) inner_base_q <= table_of(rdata);
      if (load_frame) frame_q      <= rdata[ENT_W-1:OFF_W];
    end
  end

  assign outer_idx = vaddr_q[VA_W-1:OFF_W+IN_W];
  assign inner_idx = vaddr_q[OFF_W+IN_W-1:OFF_W];
  assign mem_addr  = sel_inner ? entry_addr(inner_base_q, OUT_W'(inner_idx))
                               : entry_addr(base_q, outer_idx);
  assign paddr     = {frame_q, vaddr_q[OFF_W-1:0]};

  // R3
  inner_base_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_inner |=> (inner_base_q[OFF_W-1:0] == '0));
endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
  import ptw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  logic      in_range,
  input  logic      mem_rvalid,
  input  logic      ent_valid,
  output logic      capture,
  output logic      load_inner,
  output logic      load_frame,
  output logic      sel_inner,
  output logic      mem_req,
  output logic      rsp_valid,
  output logic      busy,
  output walk_flt_e fault
);
  walk_st_e  st_q, st_d;
  walk_flt_e flt_d;
  logic      waiting;

  always_comb begin
    st_d       = st_q;
    flt_d      = fault;
    capture    = 1'b0;
    load_inner = 1'b0;
    load_frame = 1'b0;
    sel_inner  = 1'b0;
    mem_req    = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        capture = 1'b1;
        flt_d   = FLT_NONE;
        st_d    = ST_RD_OUT;
      end
      ST_RD_OUT: if (!in_range) begin
        flt_d = FLT_BOUND;
        st_d  = ST_DONE;
      end else begin
        mem_req = 1'b1;
        st_d    = ST_WT_OUT;
      end
      ST_WT_OUT: if (mem_rvalid) begin
        if (!ent_valid) begin
          flt_d = FLT_OUTER;
          st_d  = ST_DONE;
        end else begin
          load_inner = 1'b1;
          st_d       = ST_RD_IN;
        end
      end
      ST_RD_IN: begin
        sel_inner = 1'b1;
        mem_req   = 1'b1;
        st_d      = ST_WT_IN;
      end
      ST_WT_IN: begin
        sel_inner = 1'b1;
        if (mem_rvalid) begin
          if (!ent_valid) flt_d = FLT_INNER;
          else            load_frame = 1'b1;
          st_d = ST_DONE;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      fault <= FLT_NONE;
    end else begin
      st_q  <= st_d;
      fault <= flt_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign rsp_valid = (st_q == ST_DONE);
  assign waiting   = (st_q == ST_WT_OUT) || (st_q == ST_WT_IN);

  // R8
  single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  // R8
  req_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> waiting);
  // R10
  idle_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !busy);
  // R10
  busy_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> busy && !rsp_valid);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 10,
  parameter int OUT_W = 12,
  parameter int ENT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [ENT_W-1:0] tbl_base,
  input  logic [OUT_W:0]   tbl_len,
  output logic             busy,
  output logic             rsp_valid,
  output logic [ENT_W-1:0] rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             mem_req,
  output logic [ENT_W-1:0] mem_addr,
  input  logic             mem_rvalid,
  input  logic [ENT_W-1:0] mem_rdata
);
  logic             capture, load_inner, load_frame, sel_inner, in_range;
  logic [OUT_W-1:0] outer_idx;
  logic [OUT_W:0]   len_q;
  walk_flt_e        fault;
  logic [1:0]       rd_cnt;

  ptw_bound_chk #(.OUT_W(OUT_W)) u_bound (
    .idx(outer_idx), .len(len_q), .in_range(in_range)
  );

  ptw_datapath #(.VA_W(VA_W), .OFF_W(OFF_W), .OUT_W(OUT_W), .ENT_W(ENT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .capture(capture), .load_inner(load_inner),
    .load_frame(load_frame), .sel_inner(sel_inner), .vaddr_in(req_vaddr),
    .base_in(tbl_base), .len_in(tbl_len), .rdata(mem_rdata),
    .outer_idx(outer_idx), .len_q(len_q), .mem_addr(mem_addr), .paddr(rsp_paddr)
  );

  ptw_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .in_range(in_range),
    .mem_rvalid(mem_rvalid), .ent_valid(mem_rdata[0]), .capture(capture),
    .load_inner(load_inner), .load_frame(load_frame), .sel_inner(sel_inner),
    .mem_req(mem_req), .rsp_valid(rsp_valid), .busy(busy), .fault(fault)
  );

  assign rsp_fault = fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_cnt <= '0;
    else if (capture) rd_cnt <= '0;
    else if (mem_req) rd_cnt <= rd_cnt + 2'd1;
  end

  // R5
  bound_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault == FLT_BOUND) |-> rd_cnt == 2'd0);
  // R6
  outer_fault_one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault == FLT_OUTER) |-> rd_cnt == 2'd1);
  // R8
  ok_two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault == FLT_NONE) |-> rd_cnt == 2'd2);
  // R9
  walk_index_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rsp_valid) |=> $stable(outer_idx));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] tbl_base = '0;
  logic [12:0] tbl_len = '0;
  logic        busy, rsp_valid, mem_req;
  logic [31:0] rsp_paddr, mem_addr;
  logic [1:0]  rsp_fault;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  logic [31:0] mem [logic [31:0]];
  int          lat = 0;
  int          reads = 0;
  logic [31:0] rd_addr [2];
  bit          pend = 0;
  int          cd = 0;
  logic [31:0] pend_addr;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .tbl_base(tbl_base), .tbl_len(tbl_len), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // memory responder, driven away from the active edge
  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      if (cd == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        pend = 0;
      end else cd--;
    end
    if (rst_n && mem_req) begin
      if (reads < 2) rd_addr[reads] = mem_addr;
      reads++;
      pend = 1; cd = lat; pend_addr = mem_addr;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] outer_ent(input logic [31:0] tbl, input bit v);
    return {tbl[31:10], 9'b0, v};
  endfunction

  // independent model of the address split
  function automatic logic [31:0] slot(input logic [31:0] b, input int idx);
    return b + 32'(idx) * 32'd4;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] base,
                      input logic [12:0] len, input int l, input bit intrude,
                      output logic [31:0] pa, output logic [1:0] flt, output int nrd);
    bit busy_ok = 1;
    int w = 0;
    lat = l; reads = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; tbl_base = base; tbl_len = len;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = 32'hFFFF_FFFF; tbl_base = 32'h0; tbl_len = 13'd0;
    while (!rsp_valid && w < 200) begin
      if (!busy) busy_ok = 0;
      if (intrude && w == 1) begin
        req_valid = 1'b1; req_vaddr = ~va; tbl_base = base + 32'h40; tbl_len = 13'd4096;
      end else req_valid = 1'b0;
      @(negedge clk);
      w++;
    end
    req_valid = 1'b0;
    check(busy_ok && busy, "R10 busy held during walk", {31'b0, busy}, 32'd1);
    check(rsp_valid, "R11 result strobe seen", {31'b0, rsp_valid}, 32'd1);
    pa = rsp_paddr; flt = rsp_fault;
    @(negedge clk);
    check(!rsp_valid && !busy, "R10 one-cycle result then idle",
          {30'b0, rsp_valid, busy}, 32'd0);
    repeat (3) @(negedge clk);
    nrd = reads;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !rsp_valid && !mem_req, "R1 reset outputs",
          {29'b0, busy, rsp_valid, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_ok(input logic [31:0] va, input logic [31:0] base,
                      input logic [31:0] itbl, input logic [21:0] frm,
                      input int l, input bit intrude, input logic [12:0] len);
    logic [31:0] pa; logic [1:0] f; int n;
    mem[slot(base, int'(va[31:20]))] = outer_ent(itbl, 1'b1);
    mem[slot(itbl, int'(va[19:10]))] = {frm, 9'b0, 1'b1};
    walk(va, base, len, l, intrude, pa, f, n);
    check(rd_addr[0] == slot(base, int'(va[31:20])), "R2 outer read address",
          rd_addr[0], slot(base, int'(va[31:20])));
    check(rd_addr[1] == slot(itbl, int'(va[19:10])), "R3 inner read address",
          rd_addr[1], slot(itbl, int'(va[19:10])));
    check(pa == {frm, va[9:0]} && f == 2'd0, "R4 physical address",
          pa, {frm, va[9:0]});
    check(n == 2, intrude ? "R9 busy request ignored" : "R8 two reads",
          32'(n), 32'd2);
  endtask

  initial begin
    logic [31:0] pa; logic [1:0] f; int n;
    t_reset();
    // R4 R11 zero latency
    t_ok(32'h0030_1ABC, 32'h0010_0000, 32'h0020_0400, 22'h12345, 0, 0, 13'd4096);
    // R11 long latency
    t_ok(32'hABCD_E123, 32'h0040_0000, 32'h0080_0C00, 22'h3FFFF, 7, 0, 13'd4096);
    // R9 request during walk
    t_ok(32'h0051_2C01, 32'h0010_0000, 32'h0021_0000, 22'h00ABC, 3, 1, 13'd4096);
    // R5 boundary: idx len-1 legal, top index, full length
    t_ok(32'hFFFF_FFFF, 32'h0100_0000, 32'h0300_0000, 22'h2AAAA, 1, 0, 13'd4096);
    t_ok(32'h0090_0000, 32'h0010_0000, 32'h0022_0000, 22'h00001, 0, 0, 13'd10);
    // R5 idx == len
    walk(32'h00A0_0000, 32'h0010_0000, 13'd10, 0, 0, pa, f, n);
    check(f == 2'd1, "R5 bound fault code", 32'(f), 32'd1);
    check(n == 0, "R5 no read on bound fault", 32'(n), 32'd0);
    // R5 zero length
    walk(32'h0000_0000, 32'h0010_0000, 13'd0, 0, 0, pa, f, n);
    check(f == 2'd1 && n == 0, "R5 zero length", {30'b0, f} | 32'(n << 4), 32'd1);
    // R6 outer invalid
    mem[slot(32'h0010_0000, 5)] = outer_ent(32'h0023_0000, 1'b0);
    walk(32'h0050_0000, 32'h0010_0000, 13'd4096, 2, 0, pa, f, n);
    check(f == 2'd2, "R6 outer fault code", 32'(f), 32'd2);
    check(n == 1, "R6 one read", 32'(n), 32'd1);
    // R7 inner invalid
    mem[slot(32'h0010_0000, 6)] = outer_ent(32'h0024_0000, 1'b1);
    mem[slot(32'h0024_0000, 3)] = {22'h11111, 9'b0, 1'b0};
    walk(32'h0060_0C00, 32'h0010_0000, 13'd4096, 1, 0, pa, f, n);
    check(f == 2'd3, "R7 inner fault code", 32'(f), 32'd3);
    check(n == 2, "R7 two reads", 32'(n), 32'd2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule